// File: doc/BRIEF.md
# SD Card Data-Line Block Transfer Engine

This engine moves data blocks across the data lines of a secure-digital card, using either one line or four. It runs one bit time per clock. On a read it waits for the card's start bit, bounded by an optional timeout. It then gathers the block into bytes and hands each byte to a DMA engine over a byte stream. After the block it checks the trailing CRC16 on every active line. On a write it holds the lines high for a programmable gap and sends a start bit. It then sends bytes pulled one at a time from the DMA side, followed by one CRC16 per line and an end bit. Last, it releases the lines and records the card's three-bit status token.

One start pulse runs a whole multi-block transfer, with the number of blocks set by a count input. `done` pulses once when the transfer ends. That happens after the final block, after a data timeout, or after the first block with a bad CRC or a bad status, which stops the run early. The busy flags act as self-clearing enable bits. The configuration inputs must stay stable while a transfer runs.

Top module: `sd_blk_xfer`

## Requirements
- R1: After reset both busy flags, `dat_oe`, `done`, `crc16_ok`, `crc_err`, `dto` and `crc_sts` are 0.
- R2: In 1-bit mode, line 0 carries each byte MSB first over 8 bit times. A block holds `blk_len_m1`+1 bytes, and each received byte appears on `rx_byte` with a one-cycle `rx_valid`.
- R3: In 4-bit mode each byte takes 2 bit times: the upper nibble first, then the lower, with line k carrying nibble bit k. Each line carries its own CRC16.
- R4: The CRC16 (polynomial 0x1021, zero initial value) of each active line is sent MSB first after the data. It is checked on read: `crc16_ok` gives the result of the latest block, and a mismatch sets `crc_err`.
- R5: A transfer runs `blk_cnt` blocks, moving `blk_cnt`×(`blk_len_m1`+1) bytes, and then pulses `done` once.
- R6: A CRC16 mismatch on read, or a status token other than 010 on write, ends the transfer after that block. `done` is still pulsed and `crc_err` is set.
- R7: A read waits at most `tmo_lim` bit times for a start bit (low on line 0). If none arrives, `dto` is set and `done` pulses. A start bit in the `tmo_lim`-th waiting bit time is still accepted. A value of 0 disables the limit.
- R8: Before each written block the engine drives all lines high for `wr_gap_m1`+1 bit times, with `dat_oe` high.
- R9: A written block consists of a start bit (0 on the active lines), the data bytes fetched with one `tx_req` pulse per byte, the per-line CRC16 and an end bit of 1. Unused lines stay at 1.
- R10: After the end bit, `dat_oe` falls. The engine waits for a 0 on line 0 and then captures three bits, MSB first, into `crc_sts`. Value 010 is accepted; 101 (negative) and 111 (programming error) are errors.
- R11: `rd_busy` and `wr_busy` clear by themselves when the transfer ends. A start request that arrives while a transfer is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-time clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_rd | input | 1 | Start a read transfer (taken only when idle) |
| start_wr | input | 1 | Start a write transfer (taken only when idle) |
| wide4 | input | 1 | 1 = four data lines, 0 = one line |
| blk_len_m1 | input | 11 | Bytes per block minus one |
| blk_cnt | input | 8 | Number of blocks (non-zero) |
| wr_gap_m1 | input | 4 | Write gap in bit times minus one |
| tmo_lim | input | 24 | Start-bit wait limit, 0 = unlimited |
| dat_i | input | 4 | Data lines from the card |
| dat_o | output | 4 | Data lines to the card |
| dat_oe | output | 1 | Drive enable for the data lines |
| tx_byte | input | 8 | Next byte to send, valid when requested |
| tx_req | output | 1 | Takes `tx_byte` this cycle |
| rx_byte | output | 8 | Received byte |
| rx_valid | output | 1 | `rx_byte` is valid this cycle |
| rd_busy | output | 1 | Read transfer enable, self-clearing |
| wr_busy | output | 1 | Write transfer enable, self-clearing |
| done | output | 1 | One-cycle pulse at transfer end |
| crc16_ok | output | 1 | CRC16 result of the latest read block |
| crc_err | output | 1 | CRC16 or status error in this transfer |
| dto | output | 1 | Read start-bit timeout in this transfer |
| crc_sts | output | 3 | Latest write status token |

## Verification
Reads are run with one byte, short blocks and multi-block runs, in both widths, with a clean CRC and with one CRC bit flipped in a middle block. This separates nibble order and per-line CRC from the 1-bit path, and shows whether an error really cuts the run short. Writes cover gaps from 1 to 16 bit times and status tokens 010, 101 and 111. The gap count, the byte order, the per-line CRC, the end bit and the number of bytes fetched are all compared against a model in the bench. The start-bit wait is tried one bit time inside the limit, exactly at expiry, and with the limit disabled over a long idle stretch. A write request is also injected during a read to show that it is ignored.

// File: rtl/sdx_pkg.sv
package sdx_pkg;
    parameter int LEN_W  = 11;
    parameter int CNT_W  = 8;
    parameter int GAP_W  = 4;
    parameter int TMO_W  = 24;
    parameter int LANES  = 4;
    parameter int BYTE_W = 8;
    parameter int CRC_W  = 16;
    parameter logic [CRC_W-1:0] CRC_POLY = 16'h1021;
    parameter logic [2:0] STS_GOOD = 3'b010;

    localparam int CRC_CW = $clog2(CRC_W);
    localparam int SEQ_W  = (GAP_W > CRC_CW) ? GAP_W : CRC_CW;
    localparam int BIT_W  = $clog2(BYTE_W);

    typedef enum logic [3:0] {
        ST_IDLE, ST_RWAIT, ST_RDATA, ST_RCRC, ST_REND,
        ST_WGAP, ST_WSTART, ST_WDATA, ST_WCRC, ST_WEND, ST_WSWAIT, ST_WSTS
    } sdx_state_e;

    typedef struct packed {
        sdx_state_e         st;
        logic [BYTE_W-1:0]  sh;
        logic [BIT_W-1:0]   bitc;
        logic [LEN_W-1:0]   bytec;
        logic [CNT_W-1:0]   blkc;
        logic [SEQ_W-1:0]   seq;
        logic [2:0]         sts;
        logic               done;
        logic               crc_ok;
        logic               crc_err;
        logic               dto;
    } sdx_regs_t;
endpackage

// File: rtl/sdx_crc_lane.sv
module sdx_crc_lane #(
    parameter int W = 16,
    parameter logic [W-1:0] POLY = 16'h1021
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic         bit_i,
    output logic [W-1:0] crc_o
);
    logic [W-1:0] crc_d, crc_q;
    logic         fb;

    always_comb begin
        fb    = bit_i ^ crc_q[W-1];
        crc_d = crc_q;
        if (clr)
            crc_d = '0;
        else if (en)
            crc_d = {crc_q[W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= '0;
        else        crc_q <= crc_d;
    end

    assign crc_o = crc_q;
endmodule

// File: rtl/sdx_tmo.sv
module sdx_tmo #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] lim,
    output logic         hit
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = run ? cnt_q + W'(1) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign hit = run && (lim != '0) && (cnt_q == lim - W'(1));

    // R7
    tmo_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt_q == '0);
endmodule

// File: rtl/sd_blk_xfer.sv
module sd_blk_xfer
    import sdx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_rd,
    input  logic                 start_wr,
    input  logic                 wide4,
    input  logic [LEN_W-1:0]     blk_len_m1,
    input  logic [CNT_W-1:0]     blk_cnt,
    input  logic [GAP_W-1:0]     wr_gap_m1,
    input  logic [TMO_W-1:0]     tmo_lim,
    input  logic [LANES-1:0]     dat_i,
    output logic [LANES-1:0]     dat_o,
    output logic                 dat_oe,
    input  logic [BYTE_W-1:0]    tx_byte,
    output logic                 tx_req,
    output logic [BYTE_W-1:0]    rx_byte,
    output logic                 rx_valid,
    output logic                 rd_busy,
    output logic                 wr_busy,
    output logic                 done,
    output logic                 crc16_ok,
    output logic                 crc_err,
    output logic                 dto,
    output logic [2:0]           crc_sts
);
    sdx_regs_t         r_d, r_q;
    logic [CRC_W-1:0]  crc_q [LANES];
    logic [LANES-1:0]  lane_bit, lane_act;
    logic              lane_en, lane_clr, tmo_hit, byte_last, crc_zero, last_blk;
    logic              in_read, in_write;
    logic [2:0]        sts_n;

    assign in_read  = r_q.st inside {ST_RWAIT, ST_RDATA, ST_RCRC, ST_REND};
    assign in_write = r_q.st inside {ST_WGAP, ST_WSTART, ST_WDATA, ST_WCRC,
                                     ST_WEND, ST_WSWAIT, ST_WSTS};
    assign lane_en  = r_q.st inside {ST_RDATA, ST_RCRC, ST_WDATA, ST_WCRC};
    assign lane_clr = (r_q.st == ST_RWAIT) || (r_q.st == ST_WSTART);
    assign byte_last = wide4 ? (r_q.bitc == BIT_W'(BYTE_W / LANES - 1))
                             : (r_q.bitc == BIT_W'(BYTE_W - 1));
    assign last_blk = (r_q.blkc + CNT_W'(1)) == blk_cnt;
    assign sts_n    = {r_q.sts[1:0], dat_i[0]};

    // One CRC16 per data line; line 0 alone is active in 1-bit mode.
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign lane_act[k] = wide4 || (k == 0);
        assign lane_bit[k] = in_read ? dat_i[k]
                           : (r_q.st == ST_WCRC) ? crc_q[k][CRC_W-1]
                           : (wide4 ? r_q.sh[BYTE_W-LANES+k] : r_q.sh[BYTE_W-1]);
        always_comb begin
            if (r_q.st == ST_WSTART)
                dat_o[k] = !lane_act[k];
            else if ((r_q.st == ST_WDATA) || (r_q.st == ST_WCRC))
                dat_o[k] = lane_act[k] ? lane_bit[k] : 1'b1;
            else
                dat_o[k] = 1'b1;
        end
        sdx_crc_lane #(.W(CRC_W), .POLY(CRC_POLY)) u_crc (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (lane_clr),
            .en    (lane_en && lane_act[k]),
            .bit_i (lane_bit[k]),
            .crc_o (crc_q[k])
        );
    end

    always_comb begin
        crc_zero = 1'b1;
        for (int k = 0; k < LANES; k++)
            if (lane_act[k] && (crc_q[k] != '0)) crc_zero = 1'b0;
    end

    sdx_tmo #(.W(TMO_W)) u_tmo (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (r_q.st == ST_RWAIT),
        .lim   (tmo_lim),
        .hit   (tmo_hit)
    );

    assign rx_byte = wide4 ? {r_q.sh[BYTE_W-LANES-1:0], dat_i}
                           : {r_q.sh[BYTE_W-2:0], dat_i[0]};

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        tx_req   = 1'b0;
        rx_valid = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_rd || start_wr) begin
                    r_d.st      = start_rd ? ST_RWAIT : ST_WGAP;
                    r_d.blkc    = '0;
                    r_d.seq     = '0;
                    r_d.sts     = '0;
                    r_d.crc_ok  = 1'b0;
                    r_d.crc_err = 1'b0;
                    r_d.dto     = 1'b0;
                end
            end
            ST_RWAIT: begin
                if (!dat_i[0]) begin
                    r_d.st    = ST_RDATA;
                    r_d.bitc  = '0;
                    r_d.bytec = '0;
                end else if (tmo_hit) begin
                    r_d.st   = ST_IDLE;
                    r_d.dto  = 1'b1;
                    r_d.done = 1'b1;
                end
            end
            ST_RDATA: begin
                r_d.sh   = rx_byte;
                r_d.bitc = r_q.bitc + BIT_W'(1);
                if (byte_last) begin
                    rx_valid = 1'b1;
                    r_d.bitc = '0;
                    if (r_q.bytec == blk_len_m1) begin
                        r_d.st  = ST_RCRC;
                        r_d.seq = '0;
                    end else begin
                        r_d.bytec = r_q.bytec + LEN_W'(1);
                    end
                end
            end
            ST_RCRC: begin
                r_d.seq = r_q.seq + SEQ_W'(1);
                if (r_q.seq == SEQ_W'(CRC_W - 1)) r_d.st = ST_REND;
            end
            ST_REND: begin
                r_d.crc_ok = crc_zero;
                if (!crc_zero || last_blk) begin
                    r_d.st      = ST_IDLE;
                    r_d.done    = 1'b1;
                    r_d.crc_err = !crc_zero;
                end else begin
                    r_d.st   = ST_RWAIT;
                    r_d.blkc = r_q.blkc + CNT_W'(1);
                end
            end
            ST_WGAP: begin
                if (r_q.seq == SEQ_W'(wr_gap_m1)) r_d.st = ST_WSTART;
                else                              r_d.seq = r_q.seq + SEQ_W'(1);
            end
            ST_WSTART: begin
                tx_req    = 1'b1;
                r_d.sh    = tx_byte;
                r_d.bitc  = '0;
                r_d.bytec = '0;
                r_d.st    = ST_WDATA;
            end
            ST_WDATA: begin
                r_d.bitc = r_q.bitc + BIT_W'(1);
                r_d.sh   = wide4 ? {r_q.sh[BYTE_W-LANES-1:0], {LANES{1'b0}}}
                                 : {r_q.sh[BYTE_W-2:0], 1'b0};
                if (byte_last) begin
                    r_d.bitc = '0;
                    if (r_q.bytec == blk_len_m1) begin
                        r_d.st  = ST_WCRC;
                        r_d.seq = '0;
                    end else begin
                        tx_req    = 1'b1;
                        r_d.sh    = tx_byte;
                        r_d.bytec = r_q.bytec + LEN_W'(1);
                    end
                end
            end
            ST_WCRC: begin
                r_d.seq = r_q.seq + SEQ_W'(1);
                if (r_q.seq == SEQ_W'(CRC_W - 1)) r_d.st = ST_WEND;
            end
            ST_WEND: r_d.st = ST_WSWAIT;
            ST_WSWAIT: begin
                if (!dat_i[0]) begin
                    r_d.st  = ST_WSTS;
                    r_d.seq = '0;
                end
            end
            ST_WSTS: begin
                r_d.sts = sts_n;
                r_d.seq = r_q.seq + SEQ_W'(1);
                if (r_q.seq == SEQ_W'(2)) begin
                    if ((sts_n != STS_GOOD) || last_blk) begin
                        r_d.st      = ST_IDLE;
                        r_d.done    = 1'b1;
                        r_d.crc_err = (sts_n != STS_GOOD);
                    end else begin
                        r_d.st   = ST_WGAP;
                        r_d.seq  = '0;
                        r_d.blkc = r_q.blkc + CNT_W'(1);
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_IDLE, default: '0};
        else        r_q <= r_d;
    end

    assign dat_oe   = r_q.st inside {ST_WGAP, ST_WSTART, ST_WDATA, ST_WCRC, ST_WEND};
    assign rd_busy  = in_read;
    assign wr_busy  = in_write;
    assign done     = r_q.done;
    assign crc16_ok = r_q.crc_ok;
    assign crc_err  = r_q.crc_err;
    assign dto      = r_q.dto;
    assign crc_sts  = r_q.sts;

    // R11
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_busy && start_wr) |=> !wr_busy);
    // R6
    done_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!rd_busy && !wr_busy));
    // R4
    crcerr_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(crc_err) |-> done);
    // R7
    dto_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dto) |-> (done && !crc_err));
    // R8
    gap_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dat_oe) |-> (dat_o == {LANES{1'b1}}));
    // R2
    rx_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> rd_busy);
    // R9
    txreq_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req |-> dat_oe);
endmodule

// File: tb/tb_sd_blk_xfer.sv
module tb_sd_blk_xfer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        start_rd = 0, start_wr = 0, wide4 = 0;
    logic [10:0] blk_len_m1 = 0;
    logic [7:0]  blk_cnt = 1;
    logic [3:0]  wr_gap_m1 = 0;
    logic [23:0] tmo_lim = 0;
    logic [3:0]  dat_i = 4'hF, dat_o;
    logic        dat_oe, tx_req, rx_valid, rd_busy, wr_busy, done, crc16_ok, crc_err, dto;
    logic [7:0]  tx_byte, rx_byte;
    logic [2:0]  crc_sts;

    int checks = 0, fails = 0;
    int tx_idx = 0, rx_n = 0;
    logic [7:0] rx_mem [256];

    always #(CLK_PERIOD/2) clk = ~clk;

    sd_blk_xfer dut (.*);

    function automatic logic [7:0] tx_pat(int j);
        return 8'(j * 29 + 49);
    endfunction
    function automatic logic [7:0] rd_pat(int b, int i);
        return 8'(b * 37 + i * 13 + 90);
    endfunction
    function automatic logic [15:0] crc_step(logic [15:0] c, logic b);
        logic fb = b ^ c[15];
        return {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
    endfunction

    assign tx_byte = tx_pat(tx_idx);
    always @(posedge clk) begin
        if (tx_req) tx_idx <= tx_idx + 1;
        if (rx_valid) begin
            rx_mem[rx_n % 256] <= rx_byte;
            rx_n <= rx_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    task automatic wait_done(output bit seen, output int n);
        seen = 0; n = 0;
        for (int t = 0; t < 60; t++) begin
            if (done) begin seen = 1; n = t; break; end
            @(negedge clk);
        end
    endtask

    task automatic do_read(input bit w, input int len, input int cnt, input int bad,
                           input int kidle, input int tout, input bit inj);
        logic [15:0] c [4];
        logic [3:0]  v;
        logic [7:0]  by;
        int base, nb, mism, n;
        bit stop, seen;
        wide4 = w; blk_len_m1 = 11'(len); blk_cnt = 8'(cnt); tmo_lim = 24'(tout);
        base = rx_n; nb = 0; stop = 0;
        start_rd = 1; @(negedge clk); start_rd = 0;
        for (int b = 0; b < cnt && !stop; b++) begin
            for (int t = 0; t < kidle; t++) begin
                dat_i = 4'hF;
                if (inj && b == 0) begin
                    start_wr = (t == 0);
                    // R11: write request during a read is ignored
                    if (t == 3) chk(!dat_oe && !wr_busy && rd_busy, "R11 start ignored",
                                    {dat_oe, wr_busy, rd_busy}, 3'b001);
                end
                @(negedge clk);
            end
            start_wr = 0;
            dat_i = w ? 4'h0 : 4'hE; @(negedge clk);
            for (int k = 0; k < 4; k++) c[k] = 16'h0;
            for (int i = 0; i <= len; i++) begin
                by = rd_pat(b, i);
                if (w) begin
                    for (int h = 0; h < 2; h++) begin
                        v = h ? by[3:0] : by[7:4];
                        dat_i = v;
                        for (int k = 0; k < 4; k++) c[k] = crc_step(c[k], v[k]);
                        @(negedge clk);
                    end
                end else begin
                    for (int j = 7; j >= 0; j--) begin
                        dat_i = {3'b111, by[j]};
                        c[0] = crc_step(c[0], by[j]);
                        @(negedge clk);
                    end
                end
            end
            for (int j = 15; j >= 0; j--) begin
                v = 4'hF;
                for (int k = 0; k < 4; k++) if (w || k == 0) v[k] = c[k][j];
                if (b == bad && j == 0) v[0] = ~v[0];
                dat_i = v; @(negedge clk);
            end
            dat_i = 4'hF; @(negedge clk);
            nb++;
            if (b == bad) stop = 1;
        end
        wait_done(seen, n);
        chk(seen, "R5 read done pulse", seen, 1);
        chk(crc_err == (bad < cnt), "R6 read crc_err", crc_err, bad < cnt);
        chk(crc16_ok == !(bad < cnt), "R4 crc16_ok", crc16_ok, !(bad < cnt));
        chk(dto == 0, "R7 no timeout", dto, 0);
        chk(rx_n - base == nb * (len + 1), "R5 byte total", rx_n - base, nb * (len + 1));
        mism = 0;
        for (int b = 0; b < nb; b++)
            for (int i = 0; i <= len; i++)
                if (rx_mem[(base + b * (len + 1) + i) % 256] != rd_pat(b, i)) mism++;
        chk(mism == 0, w ? "R3 4-bit read data" : "R2 1-bit read data", mism, 0);
        @(negedge clk);
        chk(!rd_busy, "R11 rd_busy cleared", rd_busy, 0);
    endtask

    task automatic do_write(input bit w, input int len, input int cnt, input int gap,
                            input int bad, input logic [2:0] bsts);
        logic [15:0] c [4];
        logic [7:0]  got;
        logic [3:0]  msk;
        logic [2:0]  s;
        int base, nbytes, gbad, dbad, cbad, ebad, gc, n;
        bit stop, seen;
        wide4 = w; blk_len_m1 = 11'(len); blk_cnt = 8'(cnt); wr_gap_m1 = 4'(gap);
        msk = w ? 4'hF : 4'h1;
        base = tx_idx; nbytes = 0; gbad = 0; dbad = 0; cbad = 0; ebad = 0; stop = 0;
        s = 3'b010;
        start_wr = 1; @(negedge clk); start_wr = 0;
        for (int b = 0; b < cnt && !stop; b++) begin
            gc = 0;
            for (int t = 0; t < 40; t++) begin
                if (dat_oe && !dat_o[0]) break;
                if (dat_oe && dat_o == 4'hF) gc++;
                @(negedge clk);
            end
            if (gc != gap + 1) gbad++;
            @(negedge clk);
            for (int k = 0; k < 4; k++) c[k] = 16'h0;
            for (int i = 0; i <= len; i++) begin
                got = 8'h00;
                if (w) begin
                    for (int h = 0; h < 2; h++) begin
                        got = {got[3:0], dat_o};
                        for (int k = 0; k < 4; k++) c[k] = crc_step(c[k], dat_o[k]);
                        @(negedge clk);
                    end
                end else begin
                    for (int j = 0; j < 8; j++) begin
                        got = {got[6:0], dat_o[0]};
                        c[0] = crc_step(c[0], dat_o[0]);
                        if (dat_o[3:1] != 3'b111) dbad++;
                        @(negedge clk);
                    end
                end
                if (got != tx_pat(base + nbytes)) dbad++;
                nbytes++;
            end
            for (int j = 15; j >= 0; j--) begin
                for (int k = 0; k < 4; k++)
                    if ((w || k == 0) && dat_o[k] != c[k][j]) cbad++;
                @(negedge clk);
            end
            if (!dat_oe || (dat_o & msk) != msk) ebad++;
            @(negedge clk);
            if (dat_oe) ebad++;
            s = (b == bad) ? bsts : 3'b010;
            dat_i = 4'hE;            @(negedge clk);
            dat_i = {3'b111, s[2]};  @(negedge clk);
            dat_i = {3'b111, s[1]};  @(negedge clk);
            dat_i = {3'b111, s[0]};  @(negedge clk);
            dat_i = 4'hF;
            if (b == bad) stop = 1;
        end
        wait_done(seen, n);
        chk(seen, "R5 write done pulse", seen, 1);
        chk(gbad == 0, "R8 write gap length", gbad, 0);
        chk(dbad == 0, w ? "R3 4-bit write data" : "R9 1-bit write data", dbad, 0);
        chk(cbad == 0, "R4 write CRC16 per line", cbad, 0);
        chk(ebad == 0, "R9 end bit and release", ebad, 0);
        chk(crc_sts == s, "R10 status captured", crc_sts, s);
        chk(crc_err == (bad < cnt), "R6 write crc_err", crc_err, bad < cnt);
        chk(tx_idx - base == nbytes, "R5 bytes fetched", tx_idx - base, nbytes);
        @(negedge clk);
        chk(!wr_busy, "R11 wr_busy cleared", wr_busy, 0);
    endtask

    typedef struct packed {
        logic        wr;
        logic        w;
        logic [10:0] len;
        logic [7:0]  cnt;
        logic [3:0]  gap;
        logic [7:0]  bad;
        logic [2:0]  sts;
    } vec_t;

    localparam vec_t VEC [8] = '{
        {1'b0, 1'b0, 11'd3, 8'd1, 4'd0,  8'hFF, 3'b010},
        {1'b0, 1'b1, 11'd7, 8'd2, 4'd0,  8'hFF, 3'b010},
        {1'b0, 1'b1, 11'd2, 8'd3, 4'd0,  8'd1,  3'b010},
        {1'b0, 1'b0, 11'd0, 8'd1, 4'd0,  8'hFF, 3'b010},
        {1'b1, 1'b0, 11'd3, 8'd1, 4'd2,  8'hFF, 3'b010},
        {1'b1, 1'b1, 11'd5, 8'd2, 4'd0,  8'hFF, 3'b010},
        {1'b1, 1'b0, 11'd1, 8'd3, 4'd5,  8'd1,  3'b101},
        {1'b1, 1'b1, 11'd0, 8'd1, 4'd15, 8'd0,  3'b111}
    };

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
        finish_run();
    end

    initial begin
        bit seen;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk({rd_busy, wr_busy, dat_oe, done} == 4'b0, "R1 idle after reset",
            {rd_busy, wr_busy, dat_oe, done}, 0);
        chk({crc16_ok, crc_err, dto, crc_sts} == 6'b0, "R1 flags after reset",
            {crc16_ok, crc_err, dto, crc_sts}, 0);

        foreach (VEC[i]) begin
            if (VEC[i].wr)
                do_write(VEC[i].w, int'(VEC[i].len), int'(VEC[i].cnt), int'(VEC[i].gap),
                         int'(VEC[i].bad), VEC[i].sts);
            else
                do_read(VEC[i].w, int'(VEC[i].len), int'(VEC[i].cnt), int'(VEC[i].bad),
                        2, 0, 1'b0);
        end

        // R7 expiry exactly after the limit with no start bit
        wide4 = 0; tmo_lim = 24'd6; dat_i = 4'hF;
        start_rd = 1; @(negedge clk); start_rd = 0;
        wait_done(seen, n);
        chk(seen && n == 6, "R7 timeout cycle", n, 6);
        chk(dto && !crc_err, "R7 timeout flag", {dto, crc_err}, 2'b10);
        @(negedge clk);
        chk(!rd_busy, "R11 rd_busy after timeout", rd_busy, 0);

        // R7 start bit in the last allowed waiting bit time
        do_read(1'b0, 0, 1, 255, 3, 4, 1'b0);
        // R7 limit disabled over a long idle stretch
        do_read(1'b1, 1, 1, 255, 40, 0, 1'b0);
        // R11 write request injected during a read
        do_read(1'b0, 1, 1, 255, 5, 0, 1'b1);

        finish_run();
    end
endmodule